// File: doc/BRIEF.md
# Dictionary Table Instruction Expander

This block sits between an instruction cache that holds compressed code and the decode stage of a pipeline. Each fetched word arrives with a flag from the address translator. The flag says whether the word is a 32-bit compressed code or a full 64-bit instruction. A compressed code is made of four 8-bit indices. Each index selects a 16-bit slice of the instruction from a dictionary that belongs to that slice position only. The four slices are concatenated to rebuild the 64-bit instruction. A word that is not compressed passes through unchanged.

The four dictionaries are loaded through a write port while the fetch path is idle. The expansion takes exactly one clock. It is either a pass-through or four table reads that run in parallel. A valid bit travels with the result, and a flush input kills the instruction that is in flight.

The package also provides a combinational check function. It reports whether a given 64-bit instruction can be encoded against a set of dictionary contents, and if it can, it returns the code. Benches and code-generation models use this function to produce compressed words that match the hardware.

Top module: `dict_expander`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0 and `out_instr` is all zeros.
- R2: `out_valid` equals the value that `in_valid` had one clock earlier, unless a flush was present in that cycle.
- R3: When `flush` is 1 in a cycle, `out_valid` is 0 in the next cycle, even if `in_valid` was 1 in that same cycle.
- R4: When `in_packed` is 0, `out_instr` one cycle later equals `in_word` bit for bit.
- R5: When `in_packed` is 1, the result is assembled from four slices. Slice k (k = 0..3) occupies bits [63-16k -: 16]. Its value is entry `in_word[31-8k -: 8]` of table k. The most significant index byte therefore selects the top slice.
- R6: Slice k reads only table k. The same index value in different byte positions returns the contents of different tables.
- R7: A write with `wr_en` = 1 stores `wr_data` at entry `wr_idx` of table `wr_sel`. A compressed word that uses that entry in a later cycle returns the new value.
- R8: A compressed word that reads an entry in the same cycle that entry is written returns the entry's previous contents.
- R9: When `in_packed` is 1, bits [63:32] of `in_word` have no effect on the result.
- R10: The package check function reports an instruction as encodable only when every slice k is present in table k. When several entries match, it picks the lowest matching index. The code it returns, once expanded by the block, reproduces the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A fetched word is present this cycle |
| in_packed | input | 1 | 1: word holds a 32-bit code in bits [31:0]; 0: full instruction |
| in_word | input | 64 | Fetched word |
| flush | input | 1 | Discard the word entering this cycle |
| wr_en | input | 1 | Dictionary write strobe |
| wr_sel | input | 2 | Table selected for the write |
| wr_idx | input | 8 | Entry written |
| wr_data | input | 16 | Value written |
| out_valid | output | 1 | Expanded instruction valid |
| out_instr | output | 64 | Expanded instruction |

## Verification
The bench loads each table with values whose top nibble identifies the table. If the byte-to-table mapping were reversed or rotated, the results would carry the wrong nibbles and the check would catch it. Compressed words are sent with garbage in the upper half, so a design that mixed raw bits into a compressed result would produce a mismatch. One entry is read in the same cycle it is written, and the bench expects the old value. A write-first memory would return the new value and be caught. A word is sent together with a flush, and `out_valid` must stay low. A design that ignored the flush would place an extra item on the scoreboard. The check function is also tested on an instruction with one slice missing from its table, and it must report that instruction as not encodable.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  localparam int SEC_W  = 16;
  localparam int IDX_W  = 8;
  localparam int N_SEC  = 4;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int INSTR_W = SEC_W * N_SEC;
  localparam int CODE_W  = IDX_W * N_SEC;

  typedef logic [SEC_W-1:0] dict_t [N_SEC][DEPTH];

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
  } pack_res_t;

  // Slice k lives at the high end for k = 0; a match needs every slice present.
  function automatic pack_res_t pack_check(input logic [INSTR_W-1:0] instr,
                                           input dict_t tbl);
    pack_res_t res;
    res.ok   = 1'b1;
    res.code = '0;
    for (int k = 0; k < N_SEC; k++) begin
      logic             hit;
      logic [SEC_W-1:0] sec;
      hit = 1'b0;
      sec = instr[INSTR_W-1-SEC_W*k -: SEC_W];
      for (int i = 0; i < DEPTH; i++) begin
        if (!hit && tbl[k][i] == sec) begin
          hit = 1'b1;
          res.code[CODE_W-1-IDX_W*k -: IDX_W] = IDX_W'(i);
        end
      end
      if (!hit) res.ok = 1'b0;
    end
    if (!res.ok) res.code = '0;
    return res;
  endfunction
endpackage

// File: rtl/dict_bank.sv
module dict_bank #(
  parameter int W  = 16,
  parameter int AW = 8,
  localparam int ENTRIES = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [ENTRIES];

  // Read-first single-clock RAM: a same-address read sees the prior contents.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/expand_select.sv
module expand_select #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         flush,
  input  logic         in_packed,
  input  logic [W-1:0] in_word,
  input  logic [W-1:0] lut_word,
  output logic         out_valid,
  output logic [W-1:0] out_instr
);
  logic         vld_q;
  logic         pk_q;
  logic [W-1:0] raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      pk_q  <= 1'b0;
      raw_q <= '0;
    end else begin
      vld_q <= in_valid & ~flush;
      pk_q  <= in_packed;
      raw_q <= in_word;
    end
  end

  // lut_word comes straight from the RAM output registers, aligned with pk_q.
  assign out_valid = vld_q;
  assign out_instr = pk_q ? lut_word : raw_q;
endmodule

// File: rtl/dict_expander.sv
module dict_expander #(
  parameter int SEC_W = dtd_pkg::SEC_W,
  parameter int IDX_W = dtd_pkg::IDX_W,
  parameter int N_SEC = dtd_pkg::N_SEC,
  localparam int INSTR_W = SEC_W * N_SEC,
  localparam int CODE_W  = IDX_W * N_SEC,
  localparam int SEL_W   = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_packed,
  input  logic [INSTR_W-1:0] in_word,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [SEC_W-1:0]   wr_data,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr
);
  logic [INSTR_W-1:0] lut_word;

  for (genvar k = 0; k < N_SEC; k++) begin : g_sec
    logic [IDX_W-1:0] ridx;
    logic             bank_we;
    assign ridx    = in_word[CODE_W-1-IDX_W*k -: IDX_W];
    assign bank_we = wr_en && (wr_sel == SEL_W'(k));

    dict_bank #(.W(SEC_W), .AW(IDX_W)) u_bank (
      .clk   (clk),
      .we    (bank_we),
      .waddr (wr_idx),
      .wdata (wr_data),
      .raddr (ridx),
      .rdata (lut_word[INSTR_W-1-SEC_W*k -: SEC_W])
    );
  end

  expand_select #(.W(INSTR_W)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .flush     (flush),
    .in_packed (in_packed),
    .in_word   (in_word),
    .lut_word  (lut_word),
    .out_valid (out_valid),
    .out_instr (out_instr)
  );
endmodule

// File: rtl/dict_expander_chk.sv
module dict_expander_chk #(
  parameter int INSTR_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_packed,
  input logic [INSTR_W-1:0] in_word,
  input logic               flush,
  input logic               out_valid,
  input logic [INSTR_W-1:0] out_instr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flush) |=> out_valid);                                      // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                                // R2
  AST_FLUSH_KILLS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);                                                    // R3
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_packed && !flush) |=> (out_instr == $past(in_word)));    // R4
endmodule

bind dict_expander dict_expander_chk #(.INSTR_W(INSTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_packed (in_packed),
  .in_word   (in_word),
  .flush     (flush),
  .out_valid (out_valid),
  .out_instr (out_instr)
);

// File: tb/tb_dict_expander.sv
module tb_dict_expander;
  import dtd_pkg::*;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_packed = 1'b0;
  logic [INSTR_W-1:0] in_word = '0;
  logic               flush = 1'b0;
  logic               wr_en = 1'b0;
  logic [1:0]         wr_sel = '0;
  logic [IDX_W-1:0]   wr_idx = '0;
  logic [SEC_W-1:0]   wr_data = '0;
  logic               out_valid;
  logic [INSTR_W-1:0] out_instr;

  always #10 clk = ~clk;

  dict_expander dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_packed(in_packed),
    .in_word(in_word), .flush(flush), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .out_valid(out_valid), .out_instr(out_instr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  dict_t model;
  logic [INSTR_W-1:0] exp_q[$];
  string              tag_q[$];

  task automatic check(input bit ok, input string req, input logic [INSTR_W-1:0] act,
                       input logic [INSTR_W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every valid output pops one expected item.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2/R3 unexpected valid", out_instr, '0);
      else begin
        logic [INSTR_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_instr == e, t, out_instr, e);
      end
    end
  end

  task automatic drive(input bit v, input bit pk, input logic [INSTR_W-1:0] w,
                       input bit fl, input bit we, input logic [1:0] ws,
                       input logic [IDX_W-1:0] wi, input logic [SEC_W-1:0] wd);
    @(negedge clk);
    in_valid = v; in_packed = pk; in_word = w; flush = fl;
    wr_en = we; wr_sel = ws; wr_idx = wi; wr_data = wd;
  endtask

  task automatic idle();
    drive(0, 0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic write_tbl(input int t, input int i, input logic [SEC_W-1:0] d);
    drive(0, 0, '0, 0, 1, 2'(t), IDX_W'(i), d);
    model[t][i] = d;
  endtask

  function automatic logic [INSTR_W-1:0] expand(input logic [CODE_W-1:0] c);
    logic [INSTR_W-1:0] r;
    for (int k = 0; k < N_SEC; k++)
      r[INSTR_W-1-SEC_W*k -: SEC_W] = model[k][c[CODE_W-1-IDX_W*k -: IDX_W]];
    return r;
  endfunction

  task automatic send_raw(input logic [INSTR_W-1:0] w, input string req);
    drive(1, 0, w, 0, 0, 0, 0, 0);
    exp_q.push_back(w); tag_q.push_back(req);
  endtask

  task automatic send_code(input logic [31:0] hi, input logic [CODE_W-1:0] c,
                           input string req);
    drive(1, 1, {hi, c}, 0, 0, 0, 0, 0);
    exp_q.push_back(expand(c)); tag_q.push_back(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 0);
    check(out_instr == '0, "R1 instr in reset", out_instr, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_instr == '0, "R1 after reset", out_instr, 0);

    // Load: top nibble names the table so misrouting shows.
    for (int t = 0; t < N_SEC; t++)
      for (int i = 0; i < DEPTH; i++)
        write_tbl(t, i, {4'(t + 1), 4'(i[3:0] ^ 4'(t)), 8'(i)});
    idle();

    // R4 pass-through
    send_raw(64'h0123_4567_89AB_CDEF, "R4 raw word");
    send_raw(64'hFFFF_0000_FFFF_0000, "R4 raw word");
    idle();
    // R5 byte to slice mapping, R6 same index in every lane, R9 upper bits junk
    send_code(32'hDEAD_BEEF, 32'h0102_0304, "R5 byte order");
    send_code(32'h1234_5678, 32'h5A5A_5A5A, "R6 per-table lookup");
    send_code(32'hFFFF_FFFF, 32'h00FF_00FF, "R9 upper bits ignored");
    for (int n = 0; n < 20; n++) begin
      if (n[0]) send_raw({$urandom, $urandom}, "R4 mixed stream");
      else send_code($urandom, $urandom, "R5 mixed stream");
    end
    idle();
    idle();

    // R3 flush with valid
    drive(1, 0, 64'hAAAA_AAAA_AAAA_AAAA, 1, 0, 0, 0, 0);
    idle();
    check(out_valid == 1'b0, "R3 flush drops word", 64'(out_valid), 0);
    // R2 gap in valid
    idle();
    check(out_valid == 1'b0, "R2 idle gives no valid", 64'(out_valid), 0);

    // R7 rewrite then use
    write_tbl(2, 7, 16'hC0DE);
    idle();
    send_code(32'h0, 32'h0000_0700, "R7 new entry visible");
    idle();

    // R8 same cycle read and write: expect old value
    begin
      logic [INSTR_W-1:0] e;
      e = expand(32'h0500_0000);
      drive(1, 1, {32'h0, 32'h0500_0000}, 0, 1, 2'd0, 8'h05, 16'hBEEF);
      model[0][5] = 16'hBEEF;
      exp_q.push_back(e); tag_q.push_back("R8 read-first");
    end
    idle();
    send_code(32'h0, 32'h0500_0000, "R8 later read sees new");
    idle();

    // R10 check function
    begin
      pack_res_t r;
      logic [INSTR_W-1:0] ins;
      ins = {model[0][9], model[1][200], model[2][7], model[3][0]};
      r = pack_check(ins, model);
      check(r.ok && r.code == 32'h09C8_0700, "R10 encodable", 64'(r.code), 64'h09C8_0700);
      send_code(32'h0, r.code, "R10 roundtrip");
      check(expand(r.code) == ins, "R10 code rebuilds instr", expand(r.code), ins);
      ins[31:16] = 16'hF123;
      r = pack_check(ins, model);
      check(!r.ok, "R10 missing slice", 64'(r.ok), 0);
    end
    idle();
    idle();
    check(exp_q.size() == 0, "R2 all items produced", 64'(exp_q.size()), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule